// File: doc/BRIEF.md
# Adaptive-Slope Delta Demodulator

This block rebuilds a signed sample stream from a one-bit-per-sample delta stream. A one-cycle strobe marks each bit. On each strobe the block captures the received bit and looks for a run of equal bits across a short history window. A run of equal bits means the slope is overloaded, so the step size grows. With no run, the step size decays toward its floor. A leaky integrator then adds or subtracts the new step, and its value is the output sample. The adaptation rules are fixed integer arithmetic, so a matching encoder that uses the same rules produces the same estimate bit for bit.

Two control inputs change how the block runs. An active-low idle input replaces the received bits with an internal alternating pattern, which drives the output to rest at mid-scale. An active-low quiescent input freezes all state and suppresses output updates. A select input chooses between a three-bit and a four-bit run detector. Output filtering and analogue conversion are done outside this block.

Top module: `cvsd_decoder`

## Requirements
- R1: After reset, `sample_out` is 0 and `sample_vld` is 0. Internally, the step size is STEP_MIN (16), the bit history is all zeros and the idle pattern phase is 0.
- R2: A strobe taken while `pwr_n`=1 raises `sample_vld` for exactly the next cycle and loads the new sample into `sample_out` at the same edge. In every other cycle `sample_vld` is 0 and `sample_out` holds its value.
- R3: A run is detected when the effective bit equals the previous two effective bits (`alg3`=1) or the previous three (`alg3`=0). The history starts as zeros.
- R4: On a run, the step grows by STEP_INC (64) and is capped at STEP_MAX (800). With no run, the step becomes step - (step >> 5) and is floored at STEP_MIN (16).
- R5: The new sample equals old - (old >>> 6) plus the new step when the effective bit is 1, or minus the new step when it is 0. The result saturates to the range -32768 to 32767.
- R6: While `idle_n`=0, the effective bits are 0,1,0,1,… The pattern starts at 0 on entry, and `rx_bit` is ignored. After 800 idle strobes the output magnitude is at most 32.
- R7: While `pwr_n`=0, strobes are ignored: no valid pulse occurs, no output change occurs and no state advances, including the idle phase. Operation resumes from the held state.
- R8: In three-bit mode, the repeating pattern 11101010000000101111 gives a peak output magnitude more than four times that of the repeating pattern 10110100100100101101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle data-clock strobe |
| rx_bit | input | 1 | Received delta bit |
| alg3 | input | 1 | 1 selects the three-bit run detector, 0 selects the four-bit one |
| idle_n | input | 1 | Active-low forced idle |
| pwr_n | input | 1 | Active-low quiescent mode |
| sample_out | output | 16 | Signed reconstructed sample |
| sample_vld | output | 1 | Pulses for one cycle after each accepted strobe |

## Verification
Forced idle and quiescent mode can fall on the same strobe. The quiescent input must win, and the alternating phase must not advance. Random stimulus toggles both inputs on strobes independently of each other, and a directed sequence enters idle, pauses and resumes. Each sample is compared with a bench model. That model advances the idle phase only on accepted strobes, so a phase slip shows as a sign error on the next output.

// File: rtl/cvsd_decoder.sv
module cvsd_decoder #(
  parameter int W         = 16,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 800,
  parameter int STEP_INC  = 64,
  parameter int DEC_SH    = 5,
  parameter int LEAK_SH   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                rx_bit,
  input  logic                alg3,
  input  logic                idle_n,
  input  logic                pwr_n,
  output logic signed [W-1:0] sample_out,
  output logic                sample_vld
);
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] POS_LIM = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [SW-1:0] NEG_LIM = $signed({3'b111, {(W-1){1'b0}}});
  localparam logic [W-1:0] SMIN = W'(STEP_MIN);
  localparam logic [W:0]   SMAX = (W+1)'(STEP_MAX);

  logic [W-1:0] step, step_n, step_dec;
  logic [W:0]   step_up;
  logic [2:0]   hist;
  logic         alt, eb, run;
  logic signed [W-1:0] leak;
  logic signed [SW-1:0] dstep, acc, acc_sat;
  wire accept = bit_stb & pwr_n;

  assign eb  = idle_n ? rx_bit : alt;
  assign run = (eb == hist[0]) && (eb == hist[1]) && (alg3 || (eb == hist[2]));

  assign step_up  = {1'b0, step} + (W+1)'(STEP_INC);
  assign step_dec = step - (step >> DEC_SH);

  always_comb begin
    if (run) step_n = (step_up > SMAX) ? SMAX[W-1:0] : step_up[W-1:0];
    else     step_n = (step_dec < SMIN) ? SMIN : step_dec;
  end

  assign leak  = sample_out >>> LEAK_SH;
  assign dstep = $signed({2'b00, step_n});
  assign acc   = {{2{sample_out[W-1]}}, sample_out} - {{2{leak[W-1]}}, leak}
               + (eb ? dstep : -dstep);

  always_comb begin
    if (acc > POS_LIM)      acc_sat = POS_LIM;
    else if (acc < NEG_LIM) acc_sat = NEG_LIM;
    else                    acc_sat = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out <= '0;
      sample_vld <= 1'b0;
      step       <= SMIN;
      hist       <= '0;
    end else begin
      sample_vld <= accept;
      if (accept) begin
        sample_out <= acc_sat[W-1:0];
        step       <= step_n;
        hist       <= {hist[1:0], eb};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alt <= 1'b0;
    else if (idle_n) alt <= 1'b0;
    else if (accept) alt <= ~alt;
  end

  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sample_vld);
  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!sample_vld && $stable(sample_out)));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_n) |=> ($stable(step) && $stable(hist) && $stable(sample_out)));
  a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step >= SMIN) && ({1'b0, step} <= SMAX));
  a_r6_alt_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !idle_n) |=> (alt != $past(alt)));
  a_r5_sign_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && eb && !sample_out[W-1]) |=> (sample_out >= $past(sample_out) - ($past(sample_out) >>> LEAK_SH)));
endmodule

// File: tb/cvsd_decoder_tb.sv
module cvsd_decoder_tb;
  logic clk = 0, rst_n = 0, bit_stb = 0, rx_bit = 0, alg3 = 1, idle_n = 1, pwr_n = 1;
  logic signed [15:0] sample_out;
  logic sample_vld;
  int checks = 0, errors = 0;
  int m_integ, m_step, m_alt;
  logic [2:0] m_hist;
  bit done = 0;

  always #10 clk = ~clk;

  cvsd_decoder u_dut (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .alg3(alg3), .idle_n(idle_n), .pwr_n(pwr_n), .sample_out(sample_out), .sample_vld(sample_vld));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    m_integ = 0; m_step = 16; m_alt = 0; m_hist = 3'b000;
  endtask

  task automatic model(input logic b, input logic a, input logic idn, input logic pw);
    logic eb;
    bit run;
    int v;
    eb = idn ? b : m_alt[0];
    if (idn) m_alt = 0;
    if (!pw) return;
    run = (eb == m_hist[0]) && (eb == m_hist[1]) && (a || eb == m_hist[2]);
    if (run) m_step = (m_step + 64 > 800) ? 800 : m_step + 64;
    else m_step = (m_step - (m_step >> 5) < 16) ? 16 : m_step - (m_step >> 5);
    v = m_integ - (m_integ >>> 6) + (eb ? m_step : -m_step);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    m_integ = v;
    m_hist = {m_hist[1:0], eb};
    if (!idn) m_alt ^= 1;
  endtask

  task automatic strobe(input logic b, input logic a, input logic idn, input logic pw, input string rq);
    int prev;
    prev = int'(sample_out);
    @(negedge clk);
    rx_bit = b; alg3 = a; idle_n = idn; pwr_n = pw; bit_stb = 1;
    @(negedge clk);
    bit_stb = 0;
    model(b, a, idn, pw);
    if (pw) chk(sample_vld === 1'b1 && int'(sample_out) == m_integ, rq, int'(sample_out), m_integ);
    else    chk(sample_vld === 1'b0 && int'(sample_out) == prev, rq, int'(sample_out), prev);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bit_stb = 0; idle_n = 1; pwr_n = 1;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction

  initial begin
    logic [19:0] pat_lo, pat_hi;
    int pk_lo, pk_hi;
    bit hit_max;
    pat_lo = 20'b10110100100100101101;
    pat_hi = 20'b11101010000000101111;
    void'($urandom(32'd619));
    model_reset();
    @(negedge clk); @(negedge clk);
    chk(sample_out == 0, "R1 reset sample", int'(sample_out), 0);
    chk(sample_vld == 0, "R1 reset valid", int'(sample_vld), 0);
    rst_n = 1;

    // R3: three ones from reset: run in 3-bit mode, none in 4-bit mode
    for (int i = 0; i < 4; i++) strobe(1, 1, 1, 1, "R3 three-bit run");
    do_reset();
    for (int i = 0; i < 4; i++) strobe(1, 0, 1, 1, "R3 four-bit run");
    do_reset();
    // R1/R3: zeros against cleared history grow the step immediately
    strobe(0, 1, 1, 1, "R1 history zeros");
    chk(int'(sample_out) == -80, "R1 first step after reset", int'(sample_out), -80);

    // R5 saturation and R4 cap
    do_reset();
    hit_max = 0;
    for (int i = 0; i < 200; i++) begin
      strobe(1, 1, 1, 1, "R5 climb");
      if (sample_out == 16'sd32767) hit_max = 1;
    end
    chk(hit_max, "R5 positive saturation", int'(sample_out), 32767);
    for (int i = 0; i < 200; i++) strobe(0, 0, 1, 1, "R4 descend");
    chk(sample_out == -16'sd32768, "R5 negative saturation", int'(sample_out), -32768);

    // R6 forced idle settles to mid-scale while rx_bit is junk
    for (int i = 0; i < 800; i++) strobe(1'($urandom), 1, 0, 1, "R6 idle pattern");
    chk(iabs(int'(sample_out)) <= 32, "R6 idle settles", int'(sample_out), 0);

    // R7 quiescent: ignore strobes, including during idle, then resume
    strobe(0, 1, 0, 1, "R6 idle step");
    for (int i = 0; i < 5; i++) strobe(1'($urandom), 1, 0, 0, "R7 frozen idle");
    for (int i = 0; i < 3; i++) strobe(1, 1, 0, 1, "R7 resume phase");
    for (int i = 0; i < 5; i++) strobe(1, 1, 1, 0, "R7 frozen normal");
    strobe(1, 1, 1, 1, "R7 resume");

    // R8 pattern amplitudes
    do_reset();
    pk_lo = 0;
    for (int r = 0; r < 10; r++)
      for (int k = 19; k >= 0; k--) begin
        strobe(pat_lo[k], 1, 1, 1, "R8 low pattern");
        if (r >= 5 && iabs(int'(sample_out)) > pk_lo) pk_lo = iabs(int'(sample_out));
      end
    do_reset();
    pk_hi = 0;
    for (int r = 0; r < 10; r++)
      for (int k = 19; k >= 0; k--) begin
        strobe(pat_hi[k], 1, 1, 1, "R8 high pattern");
        if (r >= 5 && iabs(int'(sample_out)) > pk_hi) pk_hi = iabs(int'(sample_out));
      end
    chk(pk_hi > 4 * pk_lo, "R8 amplitude ratio", pk_hi, 4 * pk_lo);

    // R2 random mix with gaps; idle and quiescent may coincide
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int gap;
      logic idn, pw, b, a;
      b = 1'($urandom);
      a = ($urandom % 8) != 0 ? alg3 : ~alg3;
      idn = ($urandom % 16) != 0 ? idle_n : ~idle_n;
      pw = ($urandom % 8) != 0;
      if ($urandom % 3 == 0) b = m_hist[0];
      strobe(b, a, idn, pw, "R2 random");
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(sample_vld == 0 && int'(sample_out) == m_integ, "R2 gap hold", int'(sample_out), m_integ);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule